// File: doc/BRIEF.md
# 16-bit Auto-Reload Timer/Counter with External Interrupt Flags

This block is one 16-bit up-counter for a small controller. It advances on one of two sources. One is an internal machine-cycle tick, one clock pulse in every `DIV` clocks. The other is a falling transition seen on an external count pin, which is sampled once per machine cycle. An external pin can gate the counter. When the count passes 16'hFFFF, it reloads from a separate pair of reload bytes and raises an overflow flag, which drives an interrupt request until an acknowledge clears it.

The same 8-bit control byte also holds the trigger mode and the pending flag for two external interrupt pins. Each pin is either edge-triggered or level-sensitive, and each flag drives its own request output. Software reaches the block through a byte-wide register bus. Writes take effect on the clock edge and reads are combinational. The three pins pass through a reset-to-high synchronizer before any logic uses them.

Top module: `ar_timer`

## Requirements
- R1: After reset all five registers read 0 and the three request outputs are low.
- R2: Register addresses are 0 = control, 1 = count low byte, 2 = count high byte, 3 = reload low byte, 4 = reload high byte. Addresses 5 to 7 read 0. Control bits: 7 gate enable, 6 external source, 5 overflow flag, 4 run, 3 int0 flag, 2 int0 edge mode, 1 int1 flag, 0 int1 edge mode. Written values read back.
- R3: With run=1, gate=0 and external source=0, the count advances by exactly one per `DIV` (12) clocks. With run=0 the count holds.
- R4: With gate=1, the counter advances only while run=1 and the synchronized int0 pin is high.
- R5: With external source=1, the count pin is sampled on each machine-cycle tick. The count advances on a tick whose sample is low when the previous sample was high. A steady pin gives no counts.
- R6: Advancing from 16'hFFFF loads the count from the reload bytes, leaves the reload bytes unchanged, and sets the overflow flag. `irq_tmr_o` equals the overflow flag.
- R7: `ack_tmr_i` clears the overflow flag. An overflow in the same cycle as the acknowledge leaves the flag set.
- R8: A control-register write sets the overflow flag and both interrupt flags to the written bit values, overriding hardware in that cycle.
- R9: In edge mode, a falling edge of the synchronized interrupt pin sets its flag and the matching acknowledge clears it. A pin that stays low does not set the flag again.
- R10: In level mode, the interrupt flag follows the inverted synchronized pin, and the acknowledge has no effect. Each `irq_xN_o` equals its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register address for read and write |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Combinational read data |
| cnt_pin_i | input | 1 | External count pin |
| xint0_i | input | 1 | External interrupt 0 pin, also the gate pin |
| xint1_i | input | 1 | External interrupt 1 pin |
| ack_tmr_i | input | 1 | Overflow interrupt acknowledge |
| ack_x0_i | input | 1 | Interrupt 0 acknowledge |
| ack_x1_i | input | 1 | Interrupt 1 acknowledge |
| irq_tmr_o | output | 1 | Overflow interrupt request |
| irq_x0_o | output | 1 | Interrupt 0 request |
| irq_x1_o | output | 1 | Interrupt 1 request |

## Verification
A prescaler out of phase or running at the wrong rate shows up as a wrong count after a window of whole machine cycles, so exact counts are checked after windows that are multiples of 12 clocks. A lost reload or a wrongly prioritized flag appears on `irq_tmr_o` in the cycle after the tick that overflows. The bench therefore finds the tick phase at the ports and lines up an acknowledge with the overflowing tick. A wrong previous-sample or previous-pin register causes missed or extra events. These show in the count after a pulse train, or on `irq_x*_o` within a few clocks of a pin change.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CLO  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CHI  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLO  = 3'd3;
  localparam logic [ADDR_W-1:0] A_RHI  = 3'd4;

  // bit order matters: software decodes it
  typedef struct packed {
    logic gate_en;
    logic src_ext;
    logic ovf;
    logic run;
    logic x0_flag;
    logic x0_edge;
    logic x1_flag;
    logic x1_edge;
  } ctrl_t;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tmr_tick_src.sv
module tmr_tick_src #(
  parameter int DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic gate_en_i,
  input  logic src_ext_i,
  input  logic gate_pin_i,
  input  logic cnt_pin_i,
  output logic inc_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PMAX = PW'(DIV - 1);

  logic [PW-1:0] pre_q;
  logic          tick;
  logic          samp_q;
  logic          fall;
  logic          enabled;

  assign tick = (pre_q == PMAX);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;

  // one pin sample per machine cycle
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   samp_q <= 1'b0;
    else if (tick) samp_q <= cnt_pin_i;

  assign fall    = samp_q & ~cnt_pin_i;
  assign enabled = run_i & (~gate_en_i | gate_pin_i);
  assign inc_o   = tick & enabled & (src_ext_i ? fall : 1'b1);

  if (DIV > 1) begin : g_gap
    // R3
    tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick |=> !tick);
  end
  // R3
  pre_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= PMAX);
  // R4
  gate_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_en_i && !gate_pin_i) |-> !inc_o);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic              wr_rlo_i,
  input  logic              wr_rhi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  rld_o,
  output logic              ovf_evt_o
);
  logic [CNT_W-1:0] cnt_q, rld_q, cnt_adv, cnt_n;

  assign ovf_evt_o = inc_i & (&cnt_q);
  assign cnt_adv   = ovf_evt_o ? rld_q : cnt_q + 1'b1;

  always_comb begin
    cnt_n = inc_i ? cnt_adv : cnt_q;
    if (wr_lo_i) cnt_n[BYTE_W-1:0]     = wdata_i;
    if (wr_hi_i) cnt_n[CNT_W-1:BYTE_W] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_n;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rld_q <= '0;
    else begin
      if (wr_rlo_i) rld_q[BYTE_W-1:0]     <= wdata_i;
      if (wr_rhi_i) rld_q[CNT_W-1:BYTE_W] <= wdata_i;
    end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;

  // R6
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_evt_o && !wr_lo_i && !wr_hi_i) |=> (cnt_q == $past(rld_q)));
  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q));
  // R3
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !(&cnt_q) && !wr_lo_i && !wr_hi_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/tmr_xint_ch.sv
module tmr_xint_ch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic edge_mode_i,
  input  logic ack_i,
  input  logic wr_i,
  input  logic wr_val_i,
  output logic flag_o
);
  logic prev_q, flag_q, fall;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= pin_i;

  assign fall = prev_q & ~pin_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          flag_q <= 1'b0;
    else if (wr_i)        flag_q <= wr_val_i;
    else if (!edge_mode_i) flag_q <= ~pin_i;
    else if (fall)        flag_q <= 1'b1;
    else if (ack_i)       flag_q <= 1'b0;

  assign flag_o = flag_q;

  // R10
  level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode_i && !wr_i) |=> (flag_q == !$past(pin_i)));
  // R9
  edge_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && fall && !wr_i) |=> flag_q);
  // R9
  ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && ack_i && !fall && !wr_i) |=> !flag_q);
endmodule

// File: rtl/ar_timer.sv
module ar_timer
  import tmr_pkg::*;
#(
  parameter int DIV = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              cnt_pin_i,
  input  logic              xint0_i,
  input  logic              xint1_i,
  input  logic              ack_tmr_i,
  input  logic              ack_x0_i,
  input  logic              ack_x1_i,
  output logic              irq_tmr_o,
  output logic              irq_x0_o,
  output logic              irq_x1_o
);
  ctrl_t            ctrl_w, ctrl_rd;
  logic             gate_en_q, src_ext_q, run_q, x0_edge_q, x1_edge_q, ovf_q;
  logic             x0_flag, x1_flag;
  logic [2:0]       pins_s;
  logic             inc, ovf_evt;
  logic [CNT_W-1:0] cnt, rld;
  logic             wr_ctrl;

  assign ctrl_w  = ctrl_t'(wr_data_i);
  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);

  tmr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) i_sync (
    .clk_i, .rst_ni,
    .d_i({xint1_i, xint0_i, cnt_pin_i}),
    .q_o(pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      gate_en_q <= 1'b0;
      src_ext_q <= 1'b0;
      run_q     <= 1'b0;
      x0_edge_q <= 1'b0;
      x1_edge_q <= 1'b0;
    end else if (wr_ctrl) begin
      gate_en_q <= ctrl_w.gate_en;
      src_ext_q <= ctrl_w.src_ext;
      run_q     <= ctrl_w.run;
      x0_edge_q <= ctrl_w.x0_edge;
      x1_edge_q <= ctrl_w.x1_edge;
    end

  // bus write wins, then overflow set, then acknowledge
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (wr_ctrl)   ovf_q <= ctrl_w.ovf;
    else if (ovf_evt)   ovf_q <= 1'b1;
    else if (ack_tmr_i) ovf_q <= 1'b0;

  tmr_tick_src #(.DIV(DIV)) i_tick (
    .clk_i, .rst_ni,
    .run_i(run_q),
    .gate_en_i(gate_en_q),
    .src_ext_i(src_ext_q),
    .gate_pin_i(pins_s[1]),
    .cnt_pin_i(pins_s[0]),
    .inc_o(inc)
  );

  tmr_count_core i_core (
    .clk_i, .rst_ni,
    .inc_i(inc),
    .wr_lo_i(wr_en_i && addr_i == A_CLO),
    .wr_hi_i(wr_en_i && addr_i == A_CHI),
    .wr_rlo_i(wr_en_i && addr_i == A_RLO),
    .wr_rhi_i(wr_en_i && addr_i == A_RHI),
    .wdata_i(wr_data_i),
    .cnt_o(cnt),
    .rld_o(rld),
    .ovf_evt_o(ovf_evt)
  );

  tmr_xint_ch i_x0 (
    .clk_i, .rst_ni,
    .pin_i(pins_s[1]),
    .edge_mode_i(x0_edge_q),
    .ack_i(ack_x0_i),
    .wr_i(wr_ctrl),
    .wr_val_i(ctrl_w.x0_flag),
    .flag_o(x0_flag)
  );

  tmr_xint_ch i_x1 (
    .clk_i, .rst_ni,
    .pin_i(pins_s[2]),
    .edge_mode_i(x1_edge_q),
    .ack_i(ack_x1_i),
    .wr_i(wr_ctrl),
    .wr_val_i(ctrl_w.x1_flag),
    .flag_o(x1_flag)
  );

  always_comb begin
    ctrl_rd = '{gate_en: gate_en_q, src_ext: src_ext_q, ovf: ovf_q, run: run_q,
                x0_flag: x0_flag, x0_edge: x0_edge_q,
                x1_flag: x1_flag, x1_edge: x1_edge_q};
    case (addr_i)
      A_CTRL:  rd_data_o = ctrl_rd;
      A_CLO:   rd_data_o = cnt[BYTE_W-1:0];
      A_CHI:   rd_data_o = cnt[CNT_W-1:BYTE_W];
      A_RLO:   rd_data_o = rld[BYTE_W-1:0];
      A_RHI:   rd_data_o = rld[CNT_W-1:BYTE_W];
      default: rd_data_o = '0;
    endcase
  end

  assign irq_tmr_o = ovf_q;
  assign irq_x0_o  = x0_flag;
  assign irq_x1_o  = x1_flag;

  // R6
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_evt && !wr_ctrl) |=> irq_tmr_o);
  // R7
  ovf_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_tmr_i && !ovf_evt && !wr_ctrl) |=> !irq_tmr_o);
  // R8
  ovf_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (irq_tmr_o == $past(wr_data_i[5])));
endmodule

// File: tb/test_ar_timer.sv
module test_ar_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       cpin = 1'b1, x0 = 1'b1, x1 = 1'b1;
  logic       ack_t = 1'b0, ack_0 = 1'b0, ack_1 = 1'b0;
  logic       irq_t, irq_0, irq_1;
  int         errors = 0, checks = 0;

  always #10 clk = ~clk;

  ar_timer i_ar_timer (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wdata), .rd_data_o(rdata), .cnt_pin_i(cpin),
    .xint0_i(x0), .xint1_i(x1), .ack_tmr_i(ack_t), .ack_x0_i(ack_0),
    .ack_x1_i(ack_1), .irq_tmr_o(irq_t), .irq_x0_o(irq_0), .irq_x1_o(irq_1)
  );

  task automatic chk(input string what, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd1, lo);
    rd(3'd2, hi);
    v = {hi, lo};
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk($sformatf("R1 reg %0d after reset", a), {8'h0, d}, 16'h0);
    end
    chk("R1 irq outputs after reset", {13'h0, irq_t, irq_0, irq_1}, 16'h0);
  endtask

  task automatic t_readback;
    logic [7:0] d;
    wr(3'd3, 8'hA5); wr(3'd4, 8'h5A);
    rd(3'd3, d); chk("R2 reload low readback", {8'h0, d}, 16'h00A5);
    rd(3'd4, d); chk("R2 reload high readback", {8'h0, d}, 16'h005A);
    wr(3'd0, 8'hC4);  // gate, ext source, int0 edge mode
    rd(3'd0, d); chk("R2 control readback", {8'h0, d}, 16'h00C4);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_timer;
    logic [15:0] v, v2;
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    wr(3'd0, 8'h10);  // run
    wait_cyc(60);
    rd16(v); chk("R3 five machine cycles", v, 16'd5);
    wr(3'd0, 8'h00);
    rd16(v);
    wait_cyc(48);
    rd16(v2); chk("R3 count holds with run=0", v2, v);
  endtask

  task automatic t_gate;
    logic [15:0] v;
    @(negedge clk) x0 = 1'b0;
    wait_cyc(4);
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    wr(3'd0, 8'h90);  // gate + run
    wait_cyc(48);
    rd16(v); chk("R4 gate pin low blocks count", v, 16'd0);
    wr(3'd0, 8'h80);
    @(negedge clk) x0 = 1'b1;
    wait_cyc(4);
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    wr(3'd0, 8'h90);
    wait_cyc(36);
    rd16(v); chk("R4 gate pin high allows count", v, 16'd3);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_overflow;
    logic [15:0] v;
    logic [7:0] d;
    wr(3'd3, 8'h34); wr(3'd4, 8'h12);
    wr(3'd1, 8'hFE); wr(3'd2, 8'hFF);
    wr(3'd0, 8'h10);
    wait_cyc(36);
    rd16(v); chk("R6 count after wrap is reload+1", v, 16'h1235);
    chk("R6 irq_tmr after overflow", {15'h0, irq_t}, 16'h1);
    rd(3'd0, d); chk("R6 overflow flag bit5", {15'h0, d[5]}, 16'h1);
    rd(3'd3, d); chk("R6 reload low unchanged", {8'h0, d}, 16'h0034);
    rd(3'd4, d); chk("R6 reload high unchanged", {8'h0, d}, 16'h0012);
    wr(3'd0, 8'h20);  // stop, keep flag
    @(negedge clk) ack_t = 1'b1;
    @(negedge clk) ack_t = 1'b0;
    chk("R7 ack clears overflow", {15'h0, irq_t}, 16'h0);
    wr(3'd0, 8'h20);
    chk("R8 write sets overflow flag", {15'h0, irq_t}, 16'h1);
    wr(3'd0, 8'h00);
    chk("R8 write clears overflow flag", {15'h0, irq_t}, 16'h0);
  endtask

  task automatic t_ack_collide;
    logic [15:0] v;
    logic [7:0] d;
    int n;
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    wr(3'd0, 8'h10);
    n = 0;
    d = 8'h00;
    while (d == 8'h00 && n < 30) begin
      @(posedge clk);
      rd(3'd1, d);
      n++;
    end
    // tick edge T found; next tick at T+12
    @(negedge clk); addr = 3'd1; wdata = 8'hFF; wr_en = 1'b1;
    @(negedge clk); addr = 3'd2;
    @(negedge clk); wr_en = 1'b0;
    repeat (9) @(negedge clk);
    ack_t = 1'b1;
    @(negedge clk) ack_t = 1'b0;
    chk("R7 overflow wins over same-cycle ack", {15'h0, irq_t}, 16'h1);
    rd16(v); chk("R6 reload at collide", v, 16'h1234);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_ext;
    logic [15:0] v;
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    wr(3'd0, 8'h50);  // ext source + run
    wait_cyc(48);
    rd16(v); chk("R5 steady pin gives no count", v, 16'd0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) cpin = 1'b0;
      repeat (30) @(negedge clk);
      cpin = 1'b1;
      repeat (30) @(negedge clk);
    end
    #1;
    rd16(v); chk("R5 four pin pulses counted", v, 16'd4);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_xint;
    logic [7:0] d;
    wr(3'd0, 8'h01);  // int1 edge mode
    chk("R9 edge mode idle", {15'h0, irq_1}, 16'h0);
    @(negedge clk) x1 = 1'b0;
    wait_cyc(5);
    chk("R9 falling edge sets int1 flag", {15'h0, irq_1}, 16'h1);
    @(negedge clk) ack_1 = 1'b1;
    @(negedge clk) ack_1 = 1'b0;
    wait_cyc(5);
    chk("R9 held low does not re-set after ack", {15'h0, irq_1}, 16'h0);
    @(negedge clk) x1 = 1'b1;
    wait_cyc(5);
    wr(3'd0, 8'h03);
    chk("R8 write sets int1 flag", {15'h0, irq_1}, 16'h1);
    wr(3'd0, 8'h00);
    @(negedge clk) x0 = 1'b0;
    wait_cyc(5);
    chk("R10 level low sets int0 request", {15'h0, irq_0}, 16'h1);
    rd(3'd0, d); chk("R10 int0 flag bit3", {15'h0, d[3]}, 16'h1);
    @(negedge clk) ack_0 = 1'b1;
    @(negedge clk) ack_0 = 1'b0;
    #1;
    chk("R10 ack ignored in level mode", {15'h0, irq_0}, 16'h1);
    @(negedge clk) x0 = 1'b1;
    wait_cyc(5);
    chk("R10 level high clears int0 request", {15'h0, irq_0}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset;
    t_readback;
    t_timer;
    t_gate;
    t_overflow;
    t_ack_collide;
    t_ext;
    t_xint;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule